// File: doc/BRIEF.md
# Tree-Reduction Index Scheduler

This block drives a reduction datapath. It emits the operand pairs of a fixed binary-tree reduction over N vector elements, one pair per cycle. The element count is written as N-1 and sampled on a start pulse. The scheduler then presents a left index and a right index with a valid flag. A consumer takes each pair by raising `advance`. The datapath combines element `right` into element `left` and writes the result back to `left`. After the final pair, element 0 holds the reduced value.

N can be any value from 1 to 128, not only a power of two. Within a layer, a pair whose right operand would fall past the end of the vector is not issued. The exact number of pairs is published on `op_count` in the same cycle that the first pair appears. A consumer can therefore use it as a vector length before iteration begins. The schedule is a pure function of N.

Top module: `tree_reduce_sched`

## Requirements
- R1: After a synchronous reset, `valid` and `done` are low and `op_count` is zero.
- R2: A `start` pulse sampled while no schedule is running loads N = `n_m1`+1. In the next cycle, `op_count` shows N-1. It then holds that value until the next accepted start.
- R3: For N of 2 or more, the first pair appears in the cycle after start, with `left_idx`=0 and `right_idx`=1.
- R4: Pairs follow layers in order. The distance d starts at 1 and doubles after each layer. A layer runs only while d < N. Inside a layer the left index starts at 0 and grows by 2d. A pair is issued only while left+d < N.
- R5: Every pair has `right_idx` = `left_idx` + d, so the right index is always greater than the left index. The last pair always has `left_idx`=0, which places the result in element 0.
- R6: While `valid` is high and `advance` is low, the pair on the outputs stays unchanged.
- R7: `last` is high exactly with the final pair. When that pair is accepted, `valid` falls and `done` pulses high for one cycle.
- R8: The number of pairs accepted before `done` equals `op_count`.
- R9: With N=1 (`n_m1`=0), no pair is issued. `done` pulses in the cycle after start.
- R10: A `start` raised while a schedule is running is ignored. The pair sequence and `op_count` continue unchanged.
- R11: The same N always produces the same sequence of pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a schedule when idle |
| n_m1 | input | 7 | Element count minus one |
| advance | input | 1 | Consumer accepts the current pair |
| valid | output | 1 | A pair is presented |
| left_idx | output | 7 | Accumulating (destination) element index |
| right_idx | output | 7 | Element folded into the left one |
| last | output | 1 | Current pair is the final one |
| done | output | 1 | One-cycle pulse when the schedule ends |
| op_count | output | 7 | Total pairs of the loaded schedule |

## Verification
The bench targets counts just past a power of two, such as 3, 5 and 65. A design that did not drop the overhanging pair there would emit a right index outside the vector. A design that stopped a layer too early would leave a partial result unmerged, which shows up as a short pair count. It also covers N=1 and N=128. A wrong N=1 path would issue a bogus pair, and a wrong N=128 path would overflow the distance or count. Random stalls on `advance` check that a design holding the pair too briefly skips entries. A start poked mid-run checks that a design which restarts loses its place and changes `op_count`.

// File: rtl/tred_pkg.sv
package tred_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_DONE = 2'd2
  } tred_state_t;
endpackage

// File: rtl/tred_step.sv
// Next-pair computation: advance within the layer, or open the next layer.
module tred_step #(
  parameter int IW = 7
) (
  input  logic [IW:0] j_i,
  input  logic [IW:0] s_i,
  input  logic [IW:0] n_i,
  output logic [IW:0] j_o,
  output logic [IW:0] s_o,
  output logic [IW:0] r_o,
  output logic        more_o
);
  localparam int XW = IW + 3;

  logic [XW-1:0] jx, sx, nx, j2, s2, rs;

  always_comb begin
    jx = {2'b00, j_i};
    sx = {2'b00, s_i};
    nx = {2'b00, n_i};
    j2 = jx + (sx << 1);
    s2 = sx << 1;
    rs = j2 + sx;
    if (rs < nx) begin
      j_o    = j2[IW:0];
      s_o    = s_i;
      r_o    = rs[IW:0];
      more_o = 1'b1;
    end else if (s2 < nx) begin
      j_o    = '0;
      s_o    = s2[IW:0];
      r_o    = s2[IW:0];
      more_o = 1'b1;
    end else begin
      j_o    = j_i;
      s_o    = s_i;
      r_o    = rs[IW:0];
      more_o = 1'b0;
    end
  end
endmodule

// File: rtl/tred_count.sv
// Holds the operation count of the loaded schedule.
module tred_count #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] n_m1,
  output logic [IW-1:0] op_count
);
  // A binary tree over N leaves has N-1 internal merges.
  always_ff @(posedge clk) begin
    if (rst)       op_count <= '0;
    else if (load) op_count <= n_m1;
  end

  AST_COUNT_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(op_count)); // R2
endmodule

// File: rtl/tree_reduce_sched.sv
module tree_reduce_sched #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] n_m1,
  input  logic          advance,
  output logic          valid,
  output logic [IW-1:0] left_idx,
  output logic [IW-1:0] right_idx,
  output logic          last,
  output logic          done,
  output logic [IW-1:0] op_count
);
  import tred_pkg::*;

  localparam int CW = IW + 1;

  tred_state_t   state_q;
  logic [CW-1:0] j_q, s_q, r_q, n_q;
  logic [CW-1:0] j_nx, s_nx, r_nx;
  logic          more;
  logic          load;
  logic [CW-1:0] n_load;

  assign load   = start && (state_q != TS_RUN);
  assign n_load = {1'b0, n_m1} + CW'(1);

  tred_step #(.IW(IW)) u_step (
    .j_i(j_q), .s_i(s_q), .n_i(n_q),
    .j_o(j_nx), .s_o(s_nx), .r_o(r_nx), .more_o(more)
  );

  tred_count #(.IW(IW)) u_count (
    .clk(clk), .rst(rst), .load(load), .n_m1(n_m1), .op_count(op_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TS_IDLE;
      j_q <= '0;
      s_q <= '0;
      r_q <= '0;
      n_q <= '0;
    end else begin
      case (state_q)
        TS_RUN: begin
          if (advance) begin
            if (more) begin
              j_q <= j_nx;
              s_q <= s_nx;
              r_q <= r_nx;
            end else begin
              state_q <= TS_DONE;
            end
          end
        end
        default: begin
          if (start) begin
            n_q     <= n_load;
            j_q     <= '0;
            s_q     <= CW'(1);
            r_q     <= CW'(1);
            state_q <= (n_m1 == '0) ? TS_DONE : TS_RUN;
          end else begin
            state_q <= TS_IDLE;
          end
        end
      endcase
    end
  end

  assign valid     = (state_q == TS_RUN);
  assign done      = (state_q == TS_DONE);
  assign left_idx  = j_q[IW-1:0];
  assign right_idx = r_q[IW-1:0];
  assign last      = valid && !more;

  // Checker-only tally of accepted pairs.
  logic [CW-1:0] tally_q;
  always_ff @(posedge clk) begin
    if (rst || load)            tally_q <= '0;
    else if (valid && advance)  tally_q <= tally_q + CW'(1);
  end

  AST_RIGHT_ABOVE_LEFT: assert property (@(posedge clk) disable iff (rst)
    valid |-> right_idx > left_idx); // R5
  AST_RIGHT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid |-> {1'b0, right_idx} < n_q); // R4
  AST_FIRST_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> (left_idx == '0) && (right_idx == IW'(1))); // R3
  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
    valid && !advance |=> valid && $stable(left_idx) && $stable(right_idx)); // R6
  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    valid && last && advance |=> done && !valid); // R7
  AST_LAST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    valid && last |-> left_idx == '0); // R5
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    valid && start |=> $stable(n_q) && $stable(op_count)); // R10
  AST_PAIR_TALLY: assert property (@(posedge clk) disable iff (rst)
    valid && last && advance |-> tally_q + CW'(1) == {1'b0, op_count}); // R8
endmodule

// File: tb/sim_tree_reduce_sched.sv
module sim_tree_reduce_sched;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [6:0] n_m1 = '0;
  logic       advance = 1'b0;
  logic       valid, last, done;
  logic [6:0] left_idx, right_idx, op_count;

  int checks = 0;
  int fails  = 0;
  int exp_l [0:127];
  int exp_r [0:127];
  int exp_cnt;

  always #2 clk = ~clk;

  tree_reduce_sched u0 (
    .clk(clk), .rst(rst), .start(start), .n_m1(n_m1), .advance(advance),
    .valid(valid), .left_idx(left_idx), .right_idx(right_idx),
    .last(last), .done(done), .op_count(op_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference schedule built from R4/R5.
  task automatic build(input int n);
    int s;
    exp_cnt = 0;
    s = 1;
    while (s < n) begin
      for (int j = 0; j + s < n; j += 2 * s) begin
        exp_l[exp_cnt] = j;
        exp_r[exp_cnt] = j + s;
        exp_cnt++;
      end
      s = s * 2;
    end
  endtask

  task automatic run_case(input int n, input int adv_pct, input bit poke, input string tag);
    int k;
    int guard;
    bit adv;
    bit held;
    build(n);
    @(negedge clk);
    n_m1 = 7'(n - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(op_count == 7'(n - 1), "R2", op_count, n - 1);
    if (n == 1) begin
      chk(done && !valid, "R9", {30'd0, done, valid}, 2);
      @(negedge clk);
      chk(!done, "R9", done, 0);
      return;
    end
    chk(valid && left_idx == 0 && right_idx == 1, "R3", right_idx, 1);
    k = 0;
    guard = 0;
    held = 1'b0;
    while (valid && guard < 2000) begin
      if (k < exp_cnt) begin
        chk(left_idx == 7'(exp_l[k]), held ? "R6" : tag, left_idx, exp_l[k]);
        chk(right_idx == 7'(exp_r[k]), held ? "R6" : "R5", right_idx, exp_r[k]);
        chk(last == (k == exp_cnt - 1), "R7", last, k == exp_cnt - 1);
      end else begin
        chk(1'b0, "R8", k, exp_cnt);
      end
      adv = ($urandom_range(99) < adv_pct);
      if (poke && k == 1) begin
        start = 1'b1;
        n_m1 = 7'($urandom_range(127));
      end else begin
        start = 1'b0;
      end
      advance = adv;
      @(negedge clk);
      if (adv) k++;
      held = !adv;
      guard++;
    end
    start = 1'b0;
    advance = 1'b0;
    chk(k == exp_cnt, "R8", k, exp_cnt);
    chk(done == 1'b1, "R7", done, 1);
    chk(op_count == 7'(n - 1), poke ? "R10" : "R2", op_count, n - 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!valid && !done, "R1", {30'd0, valid, done}, 0);
    chk(op_count == 0, "R1", op_count, 0);

    run_case(1, 100, 1'b0, "R9");
    run_case(2, 100, 1'b0, "R4");
    run_case(3, 100, 1'b0, "R4");
    run_case(5, 60, 1'b0, "R4");
    run_case(8, 50, 1'b0, "R4");
    run_case(65, 70, 1'b0, "R4");
    run_case(127, 80, 1'b0, "R4");
    run_case(128, 90, 1'b0, "R4");
    run_case(13, 40, 1'b1, "R10");
    run_case(13, 55, 1'b0, "R11");
    run_case(13, 100, 1'b0, "R11");
    for (int t = 0; t < 25; t++) begin
      run_case(int'($urandom_range(1, 128)), int'($urandom_range(30, 100)),
               1'(t % 4 == 0), "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule